// File: doc/BRIEF.md
# Conversion Result Queue with Interrupt Flags

This block sits behind an analog-to-digital sequencer and holds its results until software or a DMA engine collects them. Each incoming result carries a 16-bit processed value, a 16-bit raw value, a 5-bit channel number, an invalid bit and a clipped bit. The result is packed into a 32-bit word in the storage format selected at the time of the write, then queued first in, first out. A read strobe pops the head word. The block reports level, empty and full status at all times.

Queue events and sequencer event pulses collect in an 11-bit sticky flag register. Writing a 1 to a flag bit clears it. An enable mask selects which flags drive the single interrupt line. A DMA request is raised while DMA is enabled and the queue holds data.

The input is a valid/ready stream, but `in_ready` is tied high. The sequencer cannot be stalled. A beat offered while the queue is full is lost and recorded as an overflow. The read side uses a plain strobe that stands in for a register read. `rd_data` always shows the head word, or zero when the queue is empty.

Top module: `adc_result_fifo`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0, `level`=0), all flags are 0, and `irq`, `dma_req` and `rd_data` are 0.
- R2: With format code 0 (data with status), and also with the unused code 3, the stored word holds the data in bits 15:0, the channel in bits 20:16, invalid in bit 24, clipped in bit 31, and zeros in every other bit.
- R3: With format code 1 the stored word is the processed data in bits 15:0. With code 2 it is the raw value in bits 15:0. In both cases bits 31:16 are zero.
- R4: Words are read back in the order they were accepted. `rd_data` shows the head word, and a read strobe removes it.
- R5: `level` counts the stored words. `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0.
- R6: An input beat offered while the queue is full is dropped and sets flag bit 10 (overflow). Level and contents do not change.
- R7: While the queue is empty, `rd_data` is 0. A read strobe while empty sets flag bit 9 (underflow) and changes nothing else.
- R8: Flag bit 8 (level) is set in the cycle after `level` is greater than `cfg_thresh`. It is not set while `level` is less than or equal to the threshold.
- R9: Flags are sticky. A `flag_clr` strobe clears exactly the bits set in `flag_clr_mask`. A bit whose set condition is present in the clearing cycle stays set.
- R10: `irq` is 1 exactly when some flag bit and the same bit of `irq_en` are both 1.
- R11: `dma_req` is 1 exactly when `cfg_dma_en` is 1 and the queue is not empty.
- R12: A `flush` pulse empties the queue by the next cycle. A beat pushed in the same cycle is discarded.
- R13: A pulse on `seq_evt` bit n sets flag bit n for n = 0 and 2 to 7. `seq_evt` bit 1 is ignored, and flag bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Result beat offered |
| in_ready | output | 1 | Always 1; the sequencer is never stalled |
| in_data | input | 16 | Processed conversion value |
| in_raw | input | 16 | Raw conversion value |
| in_chan | input | 5 | Channel of the result |
| in_invalid | input | 1 | Result invalid status |
| in_clipped | input | 1 | Result clipped status |
| cfg_fmt | input | 2 | Storage format code (0 data+status, 1 data, 2 raw) |
| cfg_thresh | input | 8 | Level interrupt threshold |
| cfg_dma_en | input | 1 | Allows DMA requests |
| flush | input | 1 | Empties the queue |
| seq_evt | input | 8 | Sequencer event pulses for flag bits 0 and 2 to 7 |
| rd_en | input | 1 | Read strobe, pops the head word |
| rd_data | output | 32 | Head word, or 0 when empty |
| level | output | 8 | Number of stored words |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| irq_en | input | 11 | Interrupt enable mask |
| flag_clr | input | 1 | Write-one-to-clear strobe |
| flag_clr_mask | input | 11 | Flag bits to clear |
| irq_flags | output | 11 | Sticky flag register |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A corrupted read or write pointer shows up at the next read as a word out of order or a stale word on `rd_data`. A count that drifts is visible at once on `level`, `empty` or `full`. The level, underflow and overflow flags each follow their cause by exactly one cycle. A flag register that loses a bit, or clears the wrong one, is caught in the cycle after the clearing strobe. A mask or gating fault shows up as an `irq` or `dma_req` that disagrees with the flags and status in the same cycle.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int DATA_W = 16;
  localparam int CHAN_W = 5;
  localparam int WORD_W = 32;
  localparam int LVL_W  = 8;
  localparam int FLAG_W = 11;
  localparam int EVT_W  = 8;

  typedef enum logic [1:0] {
    FMT_FULL = 2'd0,
    FMT_DATA = 2'd1,
    FMT_RAW  = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  // flag positions owned by the queue itself
  localparam int BIT_LVL = 8;
  localparam int BIT_UFL = 9;
  localparam int BIT_OFL = 10;
  // bit 1 has no source
  localparam logic [FLAG_W-1:0] FLAG_IMPL = 11'b111_1111_1101;

  // fixed field positions of the packed word
  localparam int POS_CHAN = 16;
  localparam int POS_INV  = 24;
  localparam int POS_CLIP = 31;
endpackage

// File: rtl/adcq_pack.sv
module adcq_pack
  import adcq_pkg::*;
(
  input  logic [1:0]        fmt,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] raw,
  input  logic [CHAN_W-1:0] chan,
  input  logic              inv,
  input  logic              clip,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    unique case (fmt_e'(fmt))
      FMT_DATA: word[DATA_W-1:0] = data;
      FMT_RAW:  word[DATA_W-1:0] = raw;
      default: begin
        word[DATA_W-1:0]               = data;
        word[POS_CHAN +: CHAN_W]       = chan;
        word[POS_INV]                  = inv;
        word[POS_CLIP]                 = clip;
      end
    endcase
  end
endmodule

// File: rtl/adcq_store.sv
module adcq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          ovf_evt,
  output logic          ufl_evt
);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CFULL);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf_evt = push && full;
  assign ufl_evt = pop && empty;
  assign rdata   = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop)  rptr <= step(rptr);
      unique case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/adcq_flags.sv
module adcq_flags
  import adcq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic              clr_en,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic [FLAG_W-1:0] en_mask,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (FLAG_IMPL[i]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          flags[i] <= 1'b0;
        else if (set_vec[i])
          flags[i] <= 1'b1;
        else if (clr_en && clr_mask[i])
          flags[i] <= 1'b0;
      end
    end else begin : g_none
      assign flags[i] = 1'b0;
    end
  end

  assign irq = |(flags & en_mask);
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
  import adcq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] in_raw,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic              in_invalid,
  input  logic              in_clipped,
  input  logic [1:0]        cfg_fmt,
  input  logic [LVL_W-1:0]  cfg_thresh,
  input  logic              cfg_dma_en,
  input  logic              flush,
  input  logic [EVT_W-1:0]  seq_evt,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full,
  input  logic [FLAG_W-1:0] irq_en,
  input  logic              flag_clr,
  input  logic [FLAG_W-1:0] flag_clr_mask,
  output logic [FLAG_W-1:0] irq_flags,
  output logic              irq,
  output logic              dma_req
);
  localparam int CW = $clog2(DEPTH + 1);

  initial begin
    if (DEPTH < 1 || DEPTH >= (1 << LVL_W))
      $error("DEPTH out of range for the level field");
  end

  logic [WORD_W-1:0] packed_w;
  logic [CW-1:0]     count;
  logic              ovf_evt, ufl_evt;
  logic [FLAG_W-1:0] set_vec;

  assign in_ready = 1'b1;

  adcq_pack u_pack (
    .fmt  (cfg_fmt),
    .data (in_data),
    .raw  (in_raw),
    .chan (in_chan),
    .inv  (in_invalid),
    .clip (in_clipped),
    .word (packed_w)
  );

  adcq_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .push    (in_valid),
    .pop     (rd_en),
    .wdata   (packed_w),
    .rdata   (rd_data),
    .count   (count),
    .empty   (empty),
    .full    (full),
    .ovf_evt (ovf_evt),
    .ufl_evt (ufl_evt)
  );

  assign level = LVL_W'(count);

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < EVT_W; i++) begin
      if (FLAG_IMPL[i]) set_vec[i] = seq_evt[i];
    end
    set_vec[BIT_LVL] = (level > cfg_thresh);
    set_vec[BIT_UFL] = ufl_evt;
    set_vec[BIT_OFL] = ovf_evt;
  end

  adcq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_en   (flag_clr),
    .clr_mask (flag_clr_mask),
    .en_mask  (irq_en),
    .flags    (irq_flags),
    .irq      (irq)
  );

  assign dma_req = cfg_dma_en && !empty;
endmodule

// File: rtl/adcq_chk.sv
module adcq_chk
  import adcq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              flush,
  input logic              rd_en,
  input logic [LVL_W-1:0]  cfg_thresh,
  input logic [LVL_W-1:0]  level,
  input logic              empty,
  input logic              full,
  input logic              flag_clr,
  input logic [FLAG_W-1:0] flag_clr_mask,
  input logic [FLAG_W-1:0] irq_flags,
  input logic              irq,
  input logic              dma_req
);
  logic [FLAG_W-1:0] clr_vec;
  assign clr_vec = flag_clr ? flag_clr_mask : '0;

  a_r5_full_level: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> level == LVL_W'(DEPTH));

  a_r6_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && full |=> irq_flags[BIT_OFL]);

  a_r6_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_en && !flush |=> full);

  a_r7_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && empty |=> irq_flags[BIT_UFL]);

  a_r8_level_flag: assert property (@(posedge clk) disable iff (!rst_n)
    level > cfg_thresh |=> irq_flags[BIT_LVL]);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_flags) & ~$past(clr_vec)) & ~irq_flags) == '0));

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_flags != '0);

  a_r11_dma_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> level != '0);

  a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && level == '0);
endmodule

bind adc_result_fifo adcq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .flush         (flush),
  .rd_en         (rd_en),
  .cfg_thresh    (cfg_thresh),
  .level         (level),
  .empty         (empty),
  .full          (full),
  .flag_clr      (flag_clr),
  .flag_clr_mask (flag_clr_mask),
  .irq_flags     (irq_flags),
  .irq           (irq),
  .dma_req       (dma_req)
);

// File: tb/sim_adc_result_fifo.sv
module sim_adc_result_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0, in_raw = '0;
  logic [4:0]  in_chan = '0;
  logic        in_invalid = 1'b0, in_clipped = 1'b0;
  logic [1:0]  cfg_fmt = 2'd0;
  logic [7:0]  cfg_thresh = 8'hFF;
  logic        cfg_dma_en = 1'b0;
  logic        flush = 1'b0;
  logic [7:0]  seq_evt = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  level;
  logic        empty, full;
  logic [10:0] irq_en = '0;
  logic        flag_clr = 1'b0;
  logic [10:0] flag_clr_mask = '0;
  logic [10:0] irq_flags;
  logic        irq, dma_req;

  int nvec = 0;
  int nmis = 0;
  logic [31:0] sb[$];

  always #2.5 clk = ~clk;

  adc_result_fifo #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] f, input logic [15:0] d,
      input logic [15:0] r, input logic [4:0] c, input logic iv, input logic cl);
    case (f)
      2'd1:    return {16'h0, d};
      2'd2:    return {16'h0, r};
      default: return {cl, 6'b0, iv, 3'b0, c, d};
    endcase
  endfunction

  // driver: offers one beat, records the expected word when it must be kept
  task automatic push(input logic [15:0] d, input logic [15:0] r, input logic [4:0] c,
      input logic iv, input logic cl);
    @(negedge clk);
    if (!full) sb.push_back(model(cfg_fmt, d, r, c, iv, cl));
    in_valid = 1'b1; in_data = d; in_raw = r; in_chan = c;
    in_invalid = iv; in_clipped = cl;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compares the head word against the scoreboard, then pops it
  task automatic pop(input string tag);
    logic [31:0] e;
    @(negedge clk);
    e = (sb.size() > 0) ? sb.pop_front() : 32'h0;
    chk(tag, rd_data, e);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear(input logic [10:0] m);
    @(negedge clk);
    flag_clr = 1'b1; flag_clr_mask = m;
    @(negedge clk);
    flag_clr = 1'b0; flag_clr_mask = '0;
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk);
    seq_evt = e;
    @(negedge clk);
    seq_evt = '0;
  endtask

  initial begin
    #(200000 * 5);
    nvec++; nmis++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 level", 32'(level), 32'd0);
    chk("R1 flags", 32'(irq_flags), 32'd0);
    chk("R1 irq/dma", {30'b0, irq, dma_req}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);

    // R2 data with status, then the unused code 3
    cfg_fmt = 2'd0;
    push(16'hA5C3, 16'h1111, 5'h13, 1'b1, 1'b1);
    pop("R2 fmt0 word");
    cfg_fmt = 2'd3;
    push(16'h0F0F, 16'h2222, 5'h05, 1'b1, 1'b0);
    pop("R2 fmt3 word");

    // R3 data only and raw only
    cfg_fmt = 2'd1;
    push(16'h1234, 16'hBEEF, 5'h07, 1'b1, 1'b1);
    pop("R3 fmt1 word");
    cfg_fmt = 2'd2;
    push(16'h1234, 16'hBEEF, 5'h07, 1'b1, 1'b1);
    pop("R3 fmt2 word");

    // R4 ordering
    cfg_fmt = 2'd0;
    for (int i = 0; i < 5; i++)
      push(16'(16'h100 * i + 3), 16'h0, 5'(i * 3), i[0], i[1]);
    @(negedge clk);
    chk("R5 level after 5", 32'(level), 32'd5);
    for (int i = 0; i < 5; i++) pop("R4 order");
    @(negedge clk);
    chk("R5 empty after drain", 32'(empty), 32'd1);

    // R5 fill up
    for (int i = 0; i < DEPTH; i++)
      push(16'(16'hC000 + i), 16'h0, 5'(i), 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 full", 32'(full), 32'd1);
    chk("R5 level full", 32'(level), 32'(DEPTH));

    // R6 overflow
    clear(11'h7FF);
    push(16'hDEAD, 16'h0, 5'h1F, 1'b1, 1'b1);
    @(negedge clk);
    chk("R6 ovf flag", 32'(irq_flags[10]), 32'd1);
    chk("R6 level unchanged", 32'(level), 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) pop("R6 contents kept");
    @(negedge clk);
    chk("R6 drained", 32'(empty), 32'd1);

    // R7 underflow
    clear(11'h7FF);
    chk("R7 empty read zero", rd_data, 32'd0);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R7 ufl flag", 32'(irq_flags), 32'h200);
    chk("R7 still empty", 32'(level), 32'd0);

    // R9 clear one bit leaves others
    pulse_evt(8'h01);
    clear(11'h200);
    chk("R9 selective clear", 32'(irq_flags), 32'h001);
    clear(11'h7FF);
    chk("R9 full clear", 32'(irq_flags), 32'd0);

    // R8 threshold
    cfg_thresh = 8'd2;
    push(16'h1, 16'h0, 5'h0, 1'b0, 1'b0);
    push(16'h2, 16'h0, 5'h0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 at threshold", 32'(irq_flags[8]), 32'd0);
    push(16'h3, 16'h0, 5'h0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 above threshold", 32'(irq_flags[8]), 32'd1);
    // R9 clear while the set condition persists
    clear(11'h100);
    chk("R9 set wins over clear", 32'(irq_flags[8]), 32'd1);
    for (int i = 0; i < 3; i++) pop("R8 drain");
    clear(11'h100);
    chk("R9 cleared after drain", 32'(irq_flags[8]), 32'd0);
    cfg_thresh = 8'hFF;

    // R13 event mapping
    pulse_evt(8'h02);
    chk("R13 bit1 ignored", 32'(irq_flags), 32'd0);
    pulse_evt(8'hFF);
    chk("R13 events", 32'(irq_flags), 32'h0FD);

    // R10 masking
    clear(11'h7FF);
    pulse_evt(8'h20);
    irq_en = 11'h7FF;
    #1 chk("R10 irq enabled", 32'(irq), 32'd1);
    irq_en = 11'h7DF;
    #1 chk("R10 irq masked", 32'(irq), 32'd0);
    irq_en = 11'h020;
    #1 chk("R10 irq single", 32'(irq), 32'd1);
    clear(11'h020);
    chk("R10 irq after clear", 32'(irq), 32'd0);
    irq_en = '0;

    // R11 DMA request
    cfg_dma_en = 1'b1;
    #1 chk("R11 dma empty", 32'(dma_req), 32'd0);
    push(16'h55, 16'h0, 5'h2, 1'b0, 1'b0);
    #1 chk("R11 dma data", 32'(dma_req), 32'd1);
    cfg_dma_en = 1'b0;
    #1 chk("R11 dma disabled", 32'(dma_req), 32'd0);

    // R12 flush
    push(16'h66, 16'h0, 5'h3, 1'b0, 1'b0);
    push(16'h77, 16'h0, 5'h4, 1'b0, 1'b0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    sb.delete();
    chk("R12 flushed empty", 32'(empty), 32'd1);
    chk("R12 flushed level", 32'(level), 32'd0);
    chk("R12 rd_data zero", rd_data, 32'd0);
    push(16'h88, 16'h9, 5'h6, 1'b0, 1'b1);
    pop("R12 usable after flush");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule